// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog for an embedded system. It counts down a 16-bit counter on a slow timebase of about 1 kHz, which arrives as a square-wave tick from a real-time-clock divider and is asynchronous to the system clock. Software arms the watchdog and must service it from time to time. Each service writes a kick command that reloads the counter from a programmed reload value. If software stops servicing the watchdog and the counter expires, the block does one of two things, chosen by a mode bit. It either emits a system reset pulse of fixed length, or it raises a sticky interrupt.

Stray writes must not disarm the watchdog or feed it. For this reason every write to the control, reload and kick locations is refused unless the two writes just before it were a fixed pair of key bytes sent to the key location. Each accepted write locks the block again, so software has to unlock it before every protected access.

Register map: address 0 is the key location, address 1 is control, address 2 is the reload value and address 3 is the kick command. The control bits are: bit 0 is enable, bit 1 selects the interrupt action (1 for interrupt, 0 for reset) and bit 2 clears the interrupt. The two key bytes are 0x3C and then 0xC3, compared against `wr_data[7:0]`.

Top module: `wd_guard`

## Requirements
- R1: After reset, `wdt_rst_o` and `wdt_irq_o` are low, the watchdog is disabled, and both the reload value and the counter hold 0xFFFF.
- R2: A write to address 1, 2 or 3 takes effect only if the two writes just before it went to address 0 with low bytes 0x3C and then 0xC3. Any other write to those addresses is ignored.
- R3: A key sequence is broken by any write that does not follow the order in R2, and a broken sequence leaves the block locked. After one accepted protected write the block is locked again.
- R4: An accepted write to address 3 (kick) loads the counter with the current reload value, whatever data is written.
- R5: The tick input is synchronized into the clock domain. Each rising edge is counted exactly once, however long the tick stays high.
- R6: While enabled (control bit 0 = 1), each counted tick decrements a nonzero counter. A tick that finds the counter at zero causes a timeout and reloads the counter. A timeout therefore follows reload+1 ticks after a kick.
- R7: While disabled, the counter keeps its value through ticks and no timeout occurs. When the block is enabled again, counting resumes from the held value.
- R8: With control bit 1 = 0, a timeout drives `wdt_rst_o` high for exactly RST_CYCLES clocks (8 by default).
- R9: With control bit 1 = 1, a timeout sets `wdt_irq_o`. It stays high until an accepted control write with bit 2 = 1 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Roughly 1 kHz timebase, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 key, 1 control, 2 reload, 3 kick) |
| wr_data | input | 16 | Register write data |
| wdt_rst_o | output | 1 | System reset pulse on timeout |
| wdt_irq_o | output | 1 | Sticky timeout interrupt |

## Verification
Some rules are checked by assertions on every cycle:
- the synchronized tick never pulses on two cycles in a row;
- a held counter stays fixed while the block is disabled;
- a kick loads the reload value;
- an accepted write always locks the gate again;
- each output only ever rises in the mode that selects it.

Other behaviour can only be shown by the bench scenarios. These are the exact tick on which each timeout occurs, the rejection of malformed and missing key sequences, the interrupt staying set through refused clears, and the measured width of the reset pulse.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_KEY    = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd2;
  localparam logic [ADDR_W-1:0] A_KICK   = 2'd3;

  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_CLEAR = 2;

  localparam logic [7:0] KEY_FIRST  = 8'h3C;
  localparam logic [7:0] KEY_SECOND = 8'hC3;

  typedef enum logic [1:0] {
    GATE_LOCKED = 2'd0,
    GATE_HALF   = 2'd1,
    GATE_OPEN   = 2'd2
  } gate_st_t;
endpackage

// File: rtl/wd_tick_sync.sv
module wd_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  output logic tick_pulse_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], tick_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign tick_pulse_o = sync_q[STAGES-1] & ~last_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse_o |=> !tick_pulse_o)
    else $error("tick pulse lasted more than one cycle");
endmodule

// File: rtl/wd_key_gate.sv
module wd_key_gate
  import wd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_byte,
  output logic              grant_o
);
  gate_st_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (wr_addr == A_KEY) begin
        if (wr_byte == KEY_FIRST)
          st_d = GATE_HALF;
        else if (st_q == GATE_HALF && wr_byte == KEY_SECOND)
          st_d = GATE_OPEN;
        else
          st_d = GATE_LOCKED;
      end else begin
        st_d = GATE_LOCKED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= GATE_LOCKED;
    else        st_q <= st_d;
  end

  assign grant_o = wr_en && (wr_addr != A_KEY) && (st_q == GATE_OPEN);

  assert_relock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> (st_q == GATE_LOCKED))
    else $error("gate stayed open after an accepted write");
endmodule

// File: rtl/wd_down_counter.sv
module wd_down_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    expire_o = enable && tick && !load && (cnt_q == '0);
    cnt_ce   = load || (enable && tick);
    if (load || expire_o) cnt_d = load_val;
    else                  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '1;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(cnt_q))
    else $error("counter moved while disabled");

  assert_expire_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> enable)
    else $error("timeout while disabled");

  assert_kick_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)))
    else $error("kick did not load reload value");
endmodule

// File: rtl/wd_guard.sv
module wd_guard
  import wd_pkg::*;
#(
  parameter int CW          = 16,
  parameter int RST_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [CW-1:0] wr_data,
  output logic          wdt_rst_o,
  output logic          wdt_irq_o
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic tick_pulse, grant, expire;

  wd_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_ns), .tick_i(tick_i), .tick_pulse_o(tick_pulse));

  wd_key_gate u_gate (
    .clk(clk), .rst_n(rst_ns), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_byte(wr_data[7:0]), .grant_o(grant));

  logic          en_q, en_d, mode_q, mode_d, irq_q, irq_d;
  logic [CW-1:0] reload_q, reload_d;
  logic [RCW-1:0] rcnt_q, rcnt_d;
  logic          ctrl_we, reload_we, kick;

  assign ctrl_we   = grant && (wr_addr == A_CTRL);
  assign reload_we = grant && (wr_addr == A_RELOAD);
  assign kick      = grant && (wr_addr == A_KICK);

  wd_down_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_ns), .enable(en_q), .tick(tick_pulse),
    .load(kick), .load_val(reload_q), .expire_o(expire));

  always_comb begin
    en_d     = en_q;
    mode_d   = mode_q;
    reload_d = reload_q;
    irq_d    = irq_q;
    rcnt_d   = rcnt_q;
    if (ctrl_we) begin
      en_d   = wr_data[CB_EN];
      mode_d = wr_data[CB_MODE];
      if (wr_data[CB_CLEAR]) irq_d = 1'b0;
    end
    if (reload_we) reload_d = wr_data;
    if (expire && mode_q) irq_d = 1'b1;
    if (expire && !mode_q)      rcnt_d = RCW'(RST_CYCLES);
    else if (rcnt_q != '0)      rcnt_d = rcnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      reload_q <= '1;
      irq_q    <= 1'b0;
      rcnt_q   <= '0;
    end else begin
      en_q     <= en_d;
      mode_q   <= mode_d;
      reload_q <= reload_d;
      irq_q    <= irq_d;
      rcnt_q   <= rcnt_d;
    end
  end

  assign wdt_rst_o = (rcnt_q != '0);
  assign wdt_irq_o = irq_q;

  assert_rst_in_reset_mode_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(wdt_rst_o) |-> !$past(mode_q))
    else $error("reset pulse in interrupt mode");

  assert_irq_in_irq_mode_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(wdt_irq_o) |-> $past(mode_q))
    else $error("interrupt in reset mode");

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(wdt_irq_o) |-> $past(ctrl_we))
    else $error("interrupt dropped without a control write");
endmodule

// File: tb/wd_guard_tb.sv
module wd_guard_tb;
  localparam int RST_CYCLES = 8;
  localparam logic KIND_RST = 1'b0;
  localparam logic KIND_IRQ = 1'b1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic wdt_rst_o, wdt_irq_o;

  int checks = 0;
  int errors = 0;
  int tc = 0;
  logic [32:0] exp_q[$];

  always #2.5 clk = ~clk;

  wd_guard #(.RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .wdt_rst_o(wdt_rst_o), .wdt_irq_o(wdt_irq_o));

  task automatic check(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic expect_event(input logic kind, input int at_tick);
    exp_q.push_back({kind, 32'(at_tick)});
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(2'd0, 16'h003C);
    wr(2'd0, 16'h00C3);
  endtask

  task automatic send_tick(input int hi = 3);
    @(negedge clk);
    tick_i = 1'b1; tc++;
    repeat (hi) @(negedge clk);
    tick_i = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) send_tick();
  endtask

  logic rst_prev = 1'b0, irq_prev = 1'b0;
  int   rst_width = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if ((wdt_rst_o && !rst_prev) || (wdt_irq_o && !irq_prev)) begin
        logic kind;
        kind = wdt_irq_o && !irq_prev;
        if (exp_q.size() == 0) begin
          check(1'b0, kind ? "R9 unexpected interrupt" : "R8 unexpected reset", tc, -1);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          check(e[32] == kind, "R6 event kind", int'(kind), int'(e[32]));
          check(int'(e[31:0]) == tc, "R6 timeout tick", tc, int'(e[31:0]));
        end
      end
      if (wdt_rst_o) rst_width++;
      if (!wdt_rst_o && rst_prev) begin
        check(rst_width == RST_CYCLES, "R8 reset pulse width", rst_width, RST_CYCLES);
        rst_width = 0;
      end
      rst_prev = wdt_rst_o;
      irq_prev = wdt_irq_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!wdt_rst_o, "R1 reset low after reset", int'(wdt_rst_o), 0);
    check(!wdt_irq_o, "R1 irq low after reset", int'(wdt_irq_o), 0);
    ticks(3);
    check(!wdt_rst_o && !wdt_irq_o, "R1 disabled after reset", int'(wdt_irq_o), 0);

    // R2: locked writes ignored
    unlock(); wr(2'd2, 16'd3);
    unlock(); wr(2'd3, 16'd0);
    wr(2'd1, 16'h0003);
    ticks(6);
    check(!wdt_irq_o && !wdt_rst_o, "R2 unlocked control write ignored", int'(wdt_irq_o), 0);

    // R6: timeout after reload+1 ticks
    unlock(); wr(2'd1, 16'h0003);
    expect_event(KIND_IRQ, tc + 4);
    ticks(3);
    check(!wdt_irq_o, "R6 no timeout before reload+1 ticks", int'(wdt_irq_o), 0);
    ticks(1);
    check(wdt_irq_o, "R6 timeout at reload+1 ticks", int'(wdt_irq_o), 1);

    // R9: sticky until accepted clear
    wr(2'd1, 16'h0004);
    check(wdt_irq_o, "R9 locked clear ignored", int'(wdt_irq_o), 1);
    unlock(); wr(2'd1, 16'h0004);
    @(negedge clk);
    check(!wdt_irq_o, "R9 accepted clear drops irq", int'(wdt_irq_o), 0);

    // R7: hold while disabled, resume from held value
    ticks(5);
    unlock(); wr(2'd1, 16'h0003);
    expect_event(KIND_IRQ, tc + 4);
    ticks(3);
    check(!wdt_irq_o, "R7 held count resumes", int'(wdt_irq_o), 0);
    ticks(1);
    check(wdt_irq_o, "R7 timeout from held value", int'(wdt_irq_o), 1);
    unlock(); wr(2'd1, 16'h0004);

    // R4: regular kicks keep reset away; then R8 reset pulse
    unlock(); wr(2'd1, 16'h0001);
    for (int k = 0; k < 4; k++) begin
      ticks(2);
      unlock(); wr(2'd3, 16'hBEEF);
    end
    check(!wdt_rst_o, "R4 kicks prevent timeout", int'(wdt_rst_o), 0);
    expect_event(KIND_RST, tc + 4);
    ticks(4);
    repeat (RST_CYCLES + 2) @(negedge clk);
    unlock(); wr(2'd1, 16'h0000);

    // R3: malformed sequences leave gate locked
    unlock(); wr(2'd3, 16'd0);
    unlock(); wr(2'd1, 16'h0001);
    ticks(2);
    wr(2'd0, 16'h003C); wr(2'd0, 16'h0055); wr(2'd0, 16'h00C3); wr(2'd3, 16'd0);
    wr(2'd0, 16'h00C3); wr(2'd0, 16'h003C); wr(2'd3, 16'd0);
    expect_event(KIND_RST, tc + 2);
    ticks(2);
    check(exp_q.size() == 0, "R3 malformed key sequences rejected", exp_q.size(), 0);
    repeat (RST_CYCLES + 2) @(negedge clk);
    unlock(); wr(2'd2, 16'd7);
    wr(2'd3, 16'd0);
    expect_event(KIND_RST, tc + 4);
    ticks(4);
    check(exp_q.size() == 0, "R3 relock after accepted write", exp_q.size(), 0);
    repeat (RST_CYCLES + 2) @(negedge clk);
    unlock(); wr(2'd1, 16'h0000);

    // R5: long high ticks count once
    unlock(); wr(2'd3, 16'd0);
    unlock(); wr(2'd1, 16'h0003);
    send_tick(40); send_tick(40);
    expect_event(KIND_IRQ, tc + 6);
    ticks(5);
    check(!wdt_irq_o, "R5 long tick counted once", int'(wdt_irq_o), 0);
    ticks(1);
    check(wdt_irq_o, "R5 timeout after long ticks", int'(wdt_irq_o), 1);
    unlock(); wr(2'd1, 16'h0004);

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R6 all expected timeouts seen", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule